// File: doc/BRIEF.md
# Descriptor-Driven Memory Copy Engine

This block is a single-channel engine that copies data between two memory regions. A 256-bit channel record sets up the work: source and destination addresses, signed step values for each side, an access size code, the number of bytes in one inner (minor) pass, the current and starting outer (major) iteration counts, address corrections applied when the major loop ends, and a set of control flags. Each minor pass is a series of read-then-write beat pairs on a simple request/acknowledge memory port. The major loop repeats the minor pass until the current iteration count runs out.

Software writes the record through a configuration port. A transfer starts from the record's start flag, or from a hardware request pulse while the request enable is set. When the major loop ends, the engine sets the done flag, clears the busy flag, and can pulse an interrupt. It can also pulse an interrupt when the count reaches half. With descriptor chaining enabled, the engine then reads the next record from the address held in the destination correction field and continues with it. A bad configuration or a bus error stops the channel and sets a sticky error flag.

Top module: `desc_dma_engine`

## Requirements
- R1: The 256-bit record has these fields: srcAddr [255:224], dstAddr [223:192], byteCnt [191:160], srcLastAdj [159:128], dstLastOrNext [127:96], srcOff [95:80], dstOff [79:64], curIter [63:55], begIter [54:46], srcSize [45:43], dstSize [42:40], start 39, active 38, done 37, intMaj 36, intHalf 35, dReq 34, sgEn 33. A cfgWr pulse while the channel is idle loads the record, with active forced to 0. A cfgWr while a transfer runs is ignored.
- R2: Size codes 0, 1, 2, 4 and 5 mean 1, 2, 4, 16 and 32 bytes. A start is a configuration error when any of these holds: the codes are illegal or unequal, byteCnt is zero or not a multiple of the size, or either iteration count is zero. A configuration error sets errCfg, clears start, and makes no memory access.
- R3: A minor pass consists of byteCnt/size beats. Each beat reads size bytes at srcAddr and then writes the same bytes, in the low bytes of the bus, at dstAddr. After each read, srcAddr grows by the sign-extended srcOff. After each write, dstAddr grows by the sign-extended dstOff.
- R4: curIter drops by one at the end of each minor pass. When it would reach zero, the major loop ends: curIter is reloaded from begIter, srcLastAdj is added to srcAddr, dstLastOrNext is added to dstAddr (only when sgEn is 0), done is set and active is cleared.
- R5: A start occurs on the record's start flag, or on hwReq while reqEn is 1. A start clears start and done and sets active. Without a trigger, a loaded record makes no memory access.
- R6: An accepted cfgWr sets reqEn. A major loop end with dReq set clears reqEn. While reqEn is 0, hwReq has no effect.
- R7: majorIrq pulses for one cycle after a major loop end when intMaj is set. halfIrq pulses for one cycle when the decremented curIter equals begIter/2 (rounded down), provided intHalf is set and this is not the major loop end.
- R8: With sgEn set, a major loop end is followed by one 32-byte read (size code 5) at dstLastOrNext. The whole record is loaded from that read with done 1 and active 0. If the loaded start flag is set, the new record then begins.
- R9: A memErr response on a data read or a record fetch sets errSrc. A memErr response on a write sets errDst. Either stops the channel: active goes to 0, done is left unchanged, and no further access is made. The next accepted cfgWr clears all error flags.
- R10: A memory request keeps memReq, memAddr and memWe steady until memAck.
- R11: After reset the channel record is all zero, and memReq, reqEn, both interrupts and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWr | input | 1 | Load cfgDesc into the channel |
| cfgDesc | input | 256 | Channel record to load |
| hwReq | input | 1 | Hardware start request |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for write, 0 for read |
| memAddr | output | 32 | Byte address of the access |
| memSize | output | 3 | Size code of the access |
| memWdata | output | 256 | Write data, low bytes used |
| memAck | input | 1 | Access accepted this cycle |
| memErr | input | 1 | Bus error on the acknowledged access |
| memRdata | input | 256 | Read data, valid with memAck |
| chanState | output | 256 | Live channel record |
| reqEn | output | 1 | Hardware request enable |
| majorIrq | output | 1 | Major loop end pulse |
| halfIrq | output | 1 | Half-count pulse |
| errCfg | output | 1 | Configuration error flag |
| errSrc | output | 1 | Read-side bus error flag |
| errDst | output | 1 | Write-side bus error flag |

## Verification
The assertions check several properties on every cycle. The request is held steady until it is acknowledged. Done and active are never both set. The iteration count is never zero while the channel is busy. A configuration error never comes with a memory request. The two interrupt pulses never coincide, and a major-loop pulse always comes with done set. Only the bench scenarios can show the rest: that the beat addresses and data follow the signed steps across minor passes, that the end-of-loop corrections and count reload are correct, that a chained record is fetched and run, and that reqEn, hwReq and the bus error responses behave as required.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 16;
  localparam int ITER_W = 9;
  localparam int SZ_W   = 3;
  localparam int BUS_W  = 256;
  localparam int DESC_W = 256;
  localparam int FLAG_N = 7;
  localparam int PAD_W  = DESC_W - 5*ADDR_W - 2*OFF_W - 2*ITER_W - 2*SZ_W - FLAG_N;
  localparam logic [SZ_W-1:0] SZ_RECORD = 3'd5;

  typedef struct packed {
    logic [ADDR_W-1:0] srcAddr;
    logic [ADDR_W-1:0] dstAddr;
    logic [ADDR_W-1:0] byteCnt;
    logic [ADDR_W-1:0] srcLastAdj;
    logic [ADDR_W-1:0] dstLastOrNext;
    logic [OFF_W-1:0]  srcOff;
    logic [OFF_W-1:0]  dstOff;
    logic [ITER_W-1:0] curIter;
    logic [ITER_W-1:0] begIter;
    logic [SZ_W-1:0]   srcSize;
    logic [SZ_W-1:0]   dstSize;
    logic start;
    logic active;
    logic done;
    logic intMaj;
    logic intHalf;
    logic dReq;
    logic sgEn;
    logic [PAD_W-1:0]  pad;
  } chanDesc_t;

  typedef enum logic [1:0] {ACC_SRC, ACC_DST, ACC_REC} accSel_e;

  typedef struct packed {
    logic    loadExt;
    logic    loadMem;
    logic    beginXfer;
    logic    abortStart;
    logic    halt;
    logic    capture;
    logic    stepDst;
    logic    minorEnd;
    accSel_e sel;
  } dpStrobe_t;

  typedef struct packed {
    logic cfgOk;
    logic lastBeat;
    logic lastIter;
    logic halfHit;
  } dpStatus_t;

  function automatic logic [ADDR_W-1:0] sizeBytes(input logic [SZ_W-1:0] code);
    case (code)
      3'd0:    sizeBytes = ADDR_W'(1);
      3'd1:    sizeBytes = ADDR_W'(2);
      3'd2:    sizeBytes = ADDR_W'(4);
      3'd4:    sizeBytes = ADDR_W'(16);
      3'd5:    sizeBytes = ADDR_W'(32);
      default: sizeBytes = '0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] sext(input logic [OFF_W-1:0] v);
    sext = {{(ADDR_W-OFF_W){v[OFF_W-1]}}, v};
  endfunction
endpackage

// File: rtl/dma_desc_datapath.sv
module dma_desc_datapath
  import desc_dma_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  chanDesc_t           cfgIn,
  input  logic [BUS_W-1:0]    memRdata,
  output chanDesc_t           chan,
  output dpStatus_t           stat,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [SZ_W-1:0]     memSize,
  output logic [BUS_W-1:0]    memWdata
);
  logic [BUS_W-1:0]  dataBuf;
  logic [ADDR_W-1:0] minorLeft;
  logic [ADDR_W-1:0] srcSz;
  logic [ADDR_W-1:0] dstSz;

  assign srcSz = sizeBytes(chan.srcSize);
  assign dstSz = sizeBytes(chan.dstSize);

  always_comb begin
    stat.cfgOk    = (srcSz != '0) && (chan.srcSize == chan.dstSize) &&
                    (chan.byteCnt != '0) && ((chan.byteCnt & (srcSz - 1'b1)) == '0) &&
                    ((chan.byteCnt & (dstSz - 1'b1)) == '0) &&
                    (chan.curIter != '0) && (chan.begIter != '0);
    stat.lastBeat = (minorLeft == dstSz);
    stat.lastIter = (chan.curIter == ITER_W'(1));
    stat.halfHit  = !stat.lastIter && ((chan.curIter - ITER_W'(1)) == (chan.begIter >> 1));
  end

  always_comb begin
    case (stb.sel)
      ACC_DST: begin memAddr = chan.dstAddr;       memSize = chan.dstSize; end
      ACC_REC: begin memAddr = chan.dstLastOrNext; memSize = SZ_RECORD;    end
      default: begin memAddr = chan.srcAddr;       memSize = chan.srcSize; end
    endcase
  end
  assign memWdata = dataBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chan      <= '0;
      dataBuf   <= '0;
      minorLeft <= '0;
    end else begin
      if (stb.loadExt) begin
        chan        <= cfgIn;
        chan.active <= 1'b0;
      end
      if (stb.loadMem) begin
        chan        <= chanDesc_t'(memRdata);
        chan.done   <= 1'b1;
        chan.active <= 1'b0;
      end
      if (stb.beginXfer) begin
        chan.start  <= 1'b0;
        chan.done   <= 1'b0;
        chan.active <= 1'b1;
        minorLeft   <= chan.byteCnt;
      end
      if (stb.abortStart) chan.start <= 1'b0;
      if (stb.halt) begin
        chan.active <= 1'b0;
        chan.start  <= 1'b0;
      end
      if (stb.capture) begin
        dataBuf      <= memRdata;
        chan.srcAddr <= chan.srcAddr + sext(chan.srcOff);
      end
      if (stb.stepDst) begin
        chan.dstAddr <= chan.dstAddr + sext(chan.dstOff);
        minorLeft    <= minorLeft - dstSz;
      end
      if (stb.minorEnd) begin
        if (stat.lastIter) begin
          chan.curIter <= chan.begIter;
          chan.srcAddr <= chan.srcAddr + chan.srcLastAdj;
          if (!chan.sgEn) chan.dstAddr <= chan.dstAddr + chan.dstLastOrNext;
          chan.done    <= 1'b1;
          chan.active  <= 1'b0;
        end else begin
          chan.curIter <= chan.curIter - ITER_W'(1);
          minorLeft    <= chan.byteCnt;
        end
      end
    end
  end

  // R4: done and busy are exclusive
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    !(chan.done && chan.active));
  // R4: the count never sits at zero while busy
  a_r4_iter_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    chan.active |-> (chan.curIter != '0));
endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
  import desc_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWr,
  input  logic      hwReq,
  input  logic      memAck,
  input  logic      memErr,
  input  chanDesc_t chan,
  input  dpStatus_t stat,
  output dpStrobe_t stb,
  output logic      memReq,
  output logic      memWe,
  output logic      reqEn,
  output logic      majorIrq,
  output logic      halfIrq,
  output logic      errCfg,
  output logic      errSrc,
  output logic      errDst
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_WRITE, ST_MINOR_END, ST_FETCH
  } ctrlState_e;

  ctrlState_e state, nextState;
  logic cfgAccept;

  assign cfgAccept = (state == ST_IDLE) && cfgWr;

  always_comb begin
    stb       = '0;
    stb.sel   = ACC_SRC;
    memReq    = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (cfgWr) stb.loadExt = 1'b1;
        else if (chan.start || (hwReq && reqEn)) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (stat.cfgOk) begin
          stb.beginXfer = 1'b1;
          nextState     = ST_READ;
        end else begin
          stb.abortStart = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin stb.halt = 1'b1;    nextState = ST_IDLE;  end
          else        begin stb.capture = 1'b1; nextState = ST_WRITE; end
        end
      end
      ST_WRITE: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        stb.sel = ACC_DST;
        if (memAck) begin
          if (memErr) begin
            stb.halt  = 1'b1;
            nextState = ST_IDLE;
          end else begin
            stb.stepDst = 1'b1;
            nextState   = stat.lastBeat ? ST_MINOR_END : ST_READ;
          end
        end
      end
      ST_MINOR_END: begin
        stb.minorEnd = 1'b1;
        if (!stat.lastIter)   nextState = ST_READ;
        else if (chan.sgEn)   nextState = ST_FETCH;
        else                  nextState = ST_IDLE;
      end
      ST_FETCH: begin
        memReq  = 1'b1;
        stb.sel = ACC_REC;
        if (memAck) begin
          if (!memErr) stb.loadMem = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      reqEn    <= 1'b0;
      majorIrq <= 1'b0;
      halfIrq  <= 1'b0;
      errCfg   <= 1'b0;
      errSrc   <= 1'b0;
      errDst   <= 1'b0;
    end else begin
      state    <= nextState;
      majorIrq <= (state == ST_MINOR_END) && stat.lastIter && chan.intMaj;
      halfIrq  <= (state == ST_MINOR_END) && stat.halfHit && chan.intHalf;
      if (cfgAccept) begin
        reqEn  <= 1'b1;
        errCfg <= 1'b0;
        errSrc <= 1'b0;
        errDst <= 1'b0;
      end
      if (state == ST_CHECK && !stat.cfgOk) errCfg <= 1'b1;
      if ((state == ST_READ || state == ST_FETCH) && memAck && memErr) errSrc <= 1'b1;
      if (state == ST_WRITE && memAck && memErr) errDst <= 1'b1;
      if (state == ST_MINOR_END && stat.lastIter && chan.dReq) reqEn <= 1'b0;
    end
  end

  // R7: the two interrupt pulses never overlap
  a_r7_irq_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({majorIrq, halfIrq}));
  // R7: a major pulse is only seen with done set
  a_r7_major_with_done: assert property (@(posedge clk) disable iff (!rstN)
    majorIrq |-> chan.done);
  // R2: a configuration error never comes with a memory access
  a_r2_cfgerr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errCfg) |-> !memReq);
endmodule

// File: rtl/desc_dma_engine.sv
module desc_dma_engine
  import desc_dma_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWr,
  input  logic [DESC_W-1:0]   cfgDesc,
  input  logic                hwReq,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [SZ_W-1:0]     memSize,
  output logic [BUS_W-1:0]    memWdata,
  input  logic                memAck,
  input  logic                memErr,
  input  logic [BUS_W-1:0]    memRdata,
  output logic [DESC_W-1:0]   chanState,
  output logic                reqEn,
  output logic                majorIrq,
  output logic                halfIrq,
  output logic                errCfg,
  output logic                errSrc,
  output logic                errDst
);
  dpStrobe_t stb;
  dpStatus_t stat;
  chanDesc_t chan;
  chanDesc_t cfgIn;

  assign cfgIn     = chanDesc_t'(cfgDesc);
  assign chanState = chan;

  dma_ctrl_fsm ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .hwReq(hwReq),
    .memAck(memAck), .memErr(memErr), .chan(chan), .stat(stat),
    .stb(stb), .memReq(memReq), .memWe(memWe), .reqEn(reqEn),
    .majorIrq(majorIrq), .halfIrq(halfIrq),
    .errCfg(errCfg), .errSrc(errSrc), .errDst(errDst)
  );

  dma_desc_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgIn(cfgIn), .memRdata(memRdata),
    .chan(chan), .stat(stat), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata)
  );

  // R10: an unanswered request holds still
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));
endmodule

// File: tb/desc_dma_engine_tb_top.sv
module desc_dma_engine_tb_top;
  import desc_dma_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0;
  logic [255:0] cfgDesc = '0;
  logic hwReq = 1'b0;
  logic memReq, memWe;
  logic [31:0] memAddr;
  logic [2:0] memSize;
  logic [255:0] memWdata;
  logic memAck = 1'b0;
  logic memErr = 1'b0;
  logic [255:0] memRdata = '0;
  logic [255:0] chanState;
  logic reqEn, majorIrq, halfIrq, errCfg, errSrc, errDst;
  chanDesc_t st;
  assign st = chanDesc_t'(chanState);

  always #10 clk = ~clk;

  desc_dma_engine dut_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgDesc(cfgDesc), .hwReq(hwReq),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memAck(memAck), .memErr(memErr), .memRdata(memRdata),
    .chanState(chanState), .reqEn(reqEn), .majorIrq(majorIrq), .halfIrq(halfIrq),
    .errCfg(errCfg), .errSrc(errSrc), .errDst(errDst)
  );

  int checks = 0;
  int errors = 0;
  int wrCount, rdCount, majCnt, halfCnt, recReads, idleRun;
  logic [31:0] wrAddr [64];
  logic [255:0] wrData [64];
  logic [2:0] wrSize [64];
  int expCount;
  logic [31:0] expWA [64];
  logic [31:0] expSA [64];
  logic [2:0] expSz [64];
  logic [31:0] badRd = 32'hFFFF_FFFF;
  logic [31:0] badWr = 32'hFFFF_FFFF;
  logic [31:0] recAddr = 32'hFFFF_FFF0;
  chanDesc_t recData;

  function automatic logic [255:0] pattern(input logic [31:0] a);
    logic [255:0] p;
    for (int i = 0; i < 32; i++) p[8*i +: 8] = 8'(a + 32'(i)) ^ 8'h5A;
    return p;
  endfunction

  function automatic int bytesOf(input logic [2:0] c);
    case (c)
      3'd0: return 1; 3'd1: return 2; 3'd2: return 4;
      3'd4: return 16; 3'd5: return 32; default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // memory model, monitors
  always @(negedge clk) begin
    memAck = 1'b0;
    memErr = 1'b0;
    if (rstN && memReq && ($urandom % 4 != 0)) begin
      memAck = 1'b1;
      if (!memWe) begin
        rdCount++;
        if (memSize == 3'd5 && memAddr == recAddr) begin
          memRdata = recData;
          recReads++;
        end else memRdata = pattern(memAddr);
        memErr = (memAddr == badRd);
      end else begin
        memErr = (memAddr == badWr);
        if (!memErr && wrCount < 64) begin
          wrAddr[wrCount] = memAddr;
          wrData[wrCount] = memWdata;
          wrSize[wrCount] = memSize;
          wrCount++;
        end
      end
    end
    if (majorIrq) majCnt++;
    if (halfIrq) halfCnt++;
    if (!st.active && !memReq) idleRun++; else idleRun = 0;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addExpected(input chanDesc_t d);
    logic [31:0] s, w;
    int beats;
    s = d.srcAddr; w = d.dstAddr;
    beats = int'(d.byteCnt) / bytesOf(d.srcSize);
    for (int it = 0; it < int'(d.curIter); it++)
      for (int b = 0; b < beats; b++) begin
        if (expCount < 64) begin
          expWA[expCount] = w; expSA[expCount] = s; expSz[expCount] = d.dstSize;
        end
        expCount++;
        s = s + sx(d.srcOff);
        w = w + sx(d.dstOff);
      end
  endtask

  function automatic chanDesc_t finalOf(input chanDesc_t d);
    chanDesc_t f;
    logic [31:0] n;
    f = d;
    n = 32'(int'(d.curIter) * (int'(d.byteCnt) / bytesOf(d.srcSize)));
    f.srcAddr = d.srcAddr + n * sx(d.srcOff) + d.srcLastAdj;
    f.dstAddr = d.dstAddr + n * sx(d.dstOff) + (d.sgEn ? 32'd0 : d.dstLastOrNext);
    f.curIter = d.begIter;
    f.start = 1'b0; f.done = 1'b1; f.active = 1'b0;
    return f;
  endfunction

  function automatic int halfOf(input chanDesc_t d);
    int n = 0;
    for (int c = int'(d.curIter); c > 1; c--)
      if (c - 1 == int'(d.begIter >> 1)) n++;
    return d.intHalf ? n : 0;
  endfunction

  task automatic launch(input chanDesc_t d);
    wrCount = 0; rdCount = 0; majCnt = 0; halfCnt = 0; recReads = 0; expCount = 0;
    @(negedge clk); cfgWr = 1'b1; cfgDesc = d;
    @(negedge clk); cfgWr = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (6) @(negedge clk);
    while (idleRun < 4) @(negedge clk);
  endtask

  task automatic cmpWrites(input string req);
    logic [255:0] e, m;
    int n;
    chk(wrCount == expCount, {req, " beat count"}, 64'(wrCount), 64'(expCount));
    n = (wrCount < expCount) ? wrCount : expCount;
    for (int i = 0; i < n && i < 64; i++) begin
      e = pattern(expSA[i]);
      m = '0;
      for (int b = 0; b < bytesOf(expSz[i]); b++) m[8*b +: 8] = 8'hFF;
      chk(wrAddr[i] == expWA[i], {req, " write address"}, 64'(wrAddr[i]), 64'(expWA[i]));
      chk(((wrData[i] ^ e) & m) == '0, {req, " write data"}, wrData[i][63:0], e[63:0]);
    end
  endtask

  task automatic cmpFinal(input string req, input chanDesc_t f);
    chk(st.srcAddr == f.srcAddr, {req, " srcAddr"}, 64'(st.srcAddr), 64'(f.srcAddr));
    chk(st.dstAddr == f.dstAddr, {req, " dstAddr"}, 64'(st.dstAddr), 64'(f.dstAddr));
    chk(st.curIter == f.curIter, {req, " curIter"}, 64'(st.curIter), 64'(f.curIter));
    chk(st.done && !st.active && !st.start, {req, " done/active/start"},
        64'({st.done, st.active, st.start}), 64'(3'b100));
  endtask

  function automatic chanDesc_t mkDesc(input logic [31:0] s, input logic [31:0] w,
      input logic [2:0] sz, input int beats, input int it, input int soff, input int doff);
    chanDesc_t d;
    d = '0;
    d.srcAddr = s; d.dstAddr = w; d.srcSize = sz; d.dstSize = sz;
    d.byteCnt = 32'(beats * bytesOf(sz));
    d.curIter = 9'(it); d.begIter = 9'(it);
    d.srcOff = 16'(soff); d.dstOff = 16'(doff);
    d.start = 1'b1;
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    chanDesc_t d, d2, f;
    logic [2:0] codes [5];
    codes[0] = 3'd0; codes[1] = 3'd1; codes[2] = 3'd2; codes[3] = 3'd4; codes[4] = 3'd5;
    void'($urandom(32'd20240611));
    recData = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!memReq && chanState == '0 && !reqEn && !majorIrq && !halfIrq &&
        !errCfg && !errSrc && !errDst, "R11 reset state", 64'(chanState[63:0]), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R7 directed basic transfer
    d = mkDesc(32'h1000, 32'h2000, 3'd2, 2, 3, 4, 4);
    d.srcLastAdj = 32'hFFFF_FFE8; d.dstLastOrNext = 32'h100; d.intMaj = 1'b1;
    launch(d); addExpected(d); waitIdle();
    cmpWrites("R3 basic");
    chk(st.srcAddr == 32'h1000 && st.dstAddr == 32'h2118, "R4 basic adjust",
        64'({st.srcAddr, st.dstAddr}), 64'({32'h1000, 32'h2118}));
    cmpFinal("R4 basic", finalOf(d));
    chk(majCnt == 1 && halfCnt == 0, "R7 basic pulses", 64'({majCnt, halfCnt}), 64'({32'd1, 32'd0}));

    // R3 single-byte beats walking down
    d = mkDesc(32'h3040, 32'h5080, 3'd0, 3, 2, -1, -2);
    d.srcLastAdj = 32'd16;
    launch(d); addExpected(d); waitIdle();
    cmpWrites("R3 negative steps");
    cmpFinal("R4 negative steps", finalOf(d));

    // R7 half-count interrupt
    d = mkDesc(32'h6000, 32'h7000, 3'd1, 1, 4, 2, 2);
    d.intHalf = 1'b1;
    launch(d); addExpected(d); waitIdle();
    cmpWrites("R7 half run");
    chk(halfCnt == 1 && majCnt == 0, "R7 half pulse", 64'({halfCnt, majCnt}), 64'({32'd1, 32'd0}));

    // random transfers: R3 R4 R7
    for (int k = 0; k < 10; k++) begin
      logic [2:0] c;
      int sz;
      c = codes[$urandom % 5];
      sz = bytesOf(c);
      d = mkDesc(32'h10000 + 32'($urandom % 256) * 32, 32'h40000 + 32'($urandom % 256) * 32,
                 c, 1 + int'($urandom % 3), 1 + int'($urandom % 4),
                 sz * (int'($urandom % 4) - 1), sz * (int'($urandom % 4) - 1));
      d.begIter = 9'(1 + $urandom % 4);
      d.srcLastAdj = 32'($urandom % 64) - 32'd32;
      d.dstLastOrNext = 32'($urandom % 64);
      d.intMaj = 1'($urandom); d.intHalf = 1'($urandom);
      launch(d); addExpected(d); waitIdle();
      cmpWrites("R3 random");
      cmpFinal("R4 random", finalOf(d));
      chk(majCnt == int'(d.intMaj) && halfCnt == halfOf(d), "R7 random pulses",
          64'({majCnt, halfCnt}), 64'({32'(d.intMaj), 32'(halfOf(d))}));
    end

    // R2 configuration errors
    d = mkDesc(32'h1000, 32'h2000, 3'd2, 1, 1, 4, 4);
    d.byteCnt = 32'd6;
    launch(d); waitIdle();
    chk(errCfg && rdCount == 0 && !st.start && !st.done && !st.active, "R2 byte count not multiple",
        64'({errCfg, st.start, st.done}), 64'(3'b100));
    d = mkDesc(32'h1000, 32'h2000, 3'd2, 1, 1, 4, 4);
    d.dstSize = 3'd1;
    launch(d); waitIdle();
    chk(errCfg && rdCount == 0, "R2 size mismatch", 64'(rdCount), 64'd0);
    d = mkDesc(32'h1000, 32'h2000, 3'd3, 1, 1, 4, 4);
    d.byteCnt = 32'd8;
    launch(d); waitIdle();
    chk(errCfg && rdCount == 0, "R2 illegal code", 64'(errCfg), 64'd1);
    d = mkDesc(32'h1000, 32'h2000, 3'd2, 1, 0, 4, 4);
    launch(d); waitIdle();
    chk(errCfg && rdCount == 0, "R2 zero count", 64'(errCfg), 64'd1);

    // R9 source bus error on second read
    d = mkDesc(32'h1000, 32'h2000, 3'd2, 3, 2, 4, 4);
    badRd = 32'h1004;
    launch(d); waitIdle();
    chk(errSrc && !errDst && !errCfg, "R9 source error flag", 64'({errSrc, errDst}), 64'(2'b10));
    chk(wrCount == 1 && rdCount == 2 && !st.active && !st.done, "R9 source stop",
        64'({wrCount, rdCount}), 64'({32'd1, 32'd2}));
    badRd = 32'hFFFF_FFFF;
    // R9 destination error on first write
    d = mkDesc(32'h1000, 32'h2000, 3'd1, 2, 2, 2, 2);
    badWr = 32'h2000;
    launch(d); waitIdle();
    chk(errDst && !errSrc && wrCount == 0 && rdCount == 1 && !st.active && !st.done,
        "R9 destination error", 64'({errDst, wrCount}), 64'({1'b1, 32'd0}));
    badWr = 32'hFFFF_FFFF;

    // R5 R6 hardware request with dReq
    d = mkDesc(32'h8000, 32'h9000, 3'd2, 2, 2, 4, 4);
    d.start = 1'b0; d.dReq = 1'b1;
    launch(d); repeat (10) @(negedge clk);
    chk(rdCount == 0 && reqEn && !errSrc, "R5 no trigger no access", 64'(rdCount), 64'd0);
    chk(!errSrc && !errDst && !errCfg, "R9 errors cleared by write", 64'({errSrc, errDst, errCfg}), 64'd0);
    expCount = 0; addExpected(d);
    hwReq = 1'b1; @(negedge clk); hwReq = 1'b0;
    waitIdle();
    cmpWrites("R5 hwReq start");
    chk(!reqEn, "R6 dReq clears request enable", 64'(reqEn), 64'd0);
    f = finalOf(d);
    rdCount = 0;
    hwReq = 1'b1; @(negedge clk); hwReq = 1'b0;
    repeat (10) @(negedge clk);
    chk(rdCount == 0 && st.done && st.srcAddr == f.srcAddr, "R6 hwReq ignored when disabled",
        64'(rdCount), 64'd0);
    d.dReq = 1'b0;
    launch(d); addExpected(d);
    hwReq = 1'b1; @(negedge clk); hwReq = 1'b0;
    waitIdle();
    chk(reqEn && wrCount == expCount, "R6 enable kept without dReq", 64'(reqEn), 64'd1);

    // R1 write ignored while busy
    d = mkDesc(32'hA000, 32'hB000, 3'd2, 3, 4, 4, 4);
    d2 = mkDesc(32'hC000, 32'hD000, 3'd0, 1, 1, 1, 1);
    launch(d); addExpected(d);
    repeat (4) @(negedge clk);
    chk(st.active, "R1 busy before second write", 64'(st.active), 64'd1);
    cfgWr = 1'b1; cfgDesc = d2; @(negedge clk); cfgWr = 1'b0;
    waitIdle();
    cmpWrites("R1 busy write ignored");
    cmpFinal("R1 busy write ignored", finalOf(d));

    // R8 descriptor chaining
    d = mkDesc(32'h1100, 32'h2200, 3'd4, 1, 2, 16, 16);
    d.sgEn = 1'b1; d.intMaj = 1'b1; d.dstLastOrNext = 32'h0000_8800;
    recAddr = 32'h0000_8800;
    d2 = mkDesc(32'h3300, 32'h4400, 3'd5, 2, 1, 32, -32);
    d2.intMaj = 1'b1; d2.srcLastAdj = 32'd8;
    recData = d2;
    launch(d); addExpected(d); addExpected(d2);
    waitIdle();
    cmpWrites("R8 chained");
    chk(recReads == 1, "R8 one record fetch", 64'(recReads), 64'd1);
    cmpFinal("R8 chained", finalOf(d2));
    chk(majCnt == 2, "R8 both majors pulse", 64'(majCnt), 64'd2);
    // R9 record fetch error
    d.dstLastOrNext = 32'h0000_9900; recAddr = 32'h0000_9900; badRd = 32'h0000_9900;
    launch(d); addExpected(d); waitIdle();
    chk(errSrc && wrCount == expCount && st.done && !st.active, "R9 fetch error",
        64'({errSrc, st.done}), 64'(2'b11));
    badRd = 32'hFFFF_FFFF;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule